// File: doc/BRIEF.md
# Vertical Line Repeater (240 to 288 lines)

This block stretches a progressive field of 240 lines into 288 output lines with no vertical filtering. Incoming pixels arrive on a slow write clock and are stored, one line per slot, in a small ring of on-chip line buffers. An output formatter running on a fast read clock asks for one line at a time. For each request the block decides whether the formatter gets the next complete stored line or the line it already had. It then serves pixel reads from the chosen slot.

The pattern is fixed. Five fresh lines are followed by one re-read of the fifth, so every six output lines carry five distinct input lines. Over a field that gives 48 repeated lines. The write side tags the first line of each field when the first pixel of the field is flagged. When that line is handed out, the pattern starts over, so every field begins at the same point of the cycle.

A line becomes visible to the read side only after its last pixel has been written. The committed-line count crosses into the read clock domain as a Gray-coded pointer. If the formatter asks for a fresh line before one is complete, it gets the current line again and an overtake flag is raised.

Top module: `vline_repeater`

## Requirements
- R1: After reset the read side reports slot NBUF-1, and rd_repeat, rd_overtake and rd_sof_line are all 0.
- R2: A line can be taken only after all LINE_LEN of its pixels have been written. The committed-line pointer moves into the read clock domain one Gray bit at a time. A request made while no complete unread line exists is a stall: rd_overtake=1, rd_repeat=1, and rd_slot is unchanged.
- R3: After five fresh lines, the next request re-reads the fifth: rd_repeat=1 with rd_slot unchanged. The following request starts a new run of five.
- R4: Fresh lines occupy slots 0, 1, …, NBUF-1, 0, … in order. The first fresh line after reset is in slot 0.
- R5: rd_pix_data, one read clock after rd_pix_addr is presented, equals the pixel written at that position of the line in rd_slot. Position n is the n-th valid pixel of the line, counting from 0. A repeated line returns the same data.
- R6: A line whose first pixel came with wr_sof sets rd_sof_line=1 when it is taken, and it counts as the first of a run of five. rd_sof_line is 0 for every other output line.
- R7: rd_overtake stays set through repeats and stalls. It clears on the next fresh line.
- R8: A wr_sof pixel arriving partway through a line abandons that partial line. Writing restarts in the same slot at position 0, and the abandoned line is never committed.
- R9: A field of 240 input lines, served over 288 line requests with no stalls, yields exactly 240 fresh lines and 48 repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Input pixel clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_valid | input | 1 | Pixel on wr_data is valid this cycle |
| wr_sof | input | 1 | With wr_valid: this pixel is the first of a field |
| wr_data | input | DATA_W | Pixel value |
| rd_clk | input | 1 | Output clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| rd_line_start | input | 1 | Formatter requests the next output line (one cycle pulse) |
| rd_pix_addr | input | clog2(LINE_LEN) | Pixel position to read in the current line |
| rd_pix_data | output | DATA_W | Pixel at rd_pix_addr, one cycle later |
| rd_slot | output | clog2(NBUF) | Line buffer slot serving the current output line |
| rd_repeat | output | 1 | Current output line re-reads the previous one |
| rd_sof_line | output | 1 | Current output line is the first line of a field |
| rd_overtake | output | 1 | Read side asked for a line not yet complete |

## Verification
The bench requests a line before any line exists and again while one is half written. A design that published the pointer early, per pixel rather than per line, would hand out a torn line and leave the flag clear. It runs the five-then-repeat pattern across the slot wrap, where an off-by-one run length or a slot counter that skips shows up as a wrong slot or a wrong pixel value. A field marker is delivered mid-line after a partial write. A design that committed the partial line, or that failed to restart the pattern, would serve stale pixels or put the repeat in the wrong place. A full 240-line field checks that the repeats total 48.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

    // Fresh lines handed out before one re-read.
    localparam int NEW_RUN = 5;
    localparam int PHASE_W = 3;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_FRESH,
        REQ_REPEAT,
        REQ_STALL
    } req_kind_e;

endpackage

// File: rtl/vlr_line_ram.sv
module vlr_line_ram #(
    parameter int  DATA_W   = 16,
    parameter int  LINE_LEN = 320,
    parameter int  NBUF     = 4,
    localparam int PIX_W    = $clog2(LINE_LEN),
    localparam int SLOT_W   = $clog2(NBUF),
    localparam int DEPTH    = NBUF * LINE_LEN,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [PIX_W-1:0]  wr_pix,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_we,
    input  logic              flag_val,
    input  logic              rd_clk,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [PIX_W-1:0]  rd_pix,
    output logic [DATA_W-1:0] rd_data,
    output logic [NBUF-1:0]   sof_flags
);

    function automatic logic [ADDR_W-1:0] flat_addr(input logic [SLOT_W-1:0] s,
                                                     input logic [PIX_W-1:0]  p);
        return ADDR_W'(s) * ADDR_W'(LINE_LEN) + ADDR_W'(p);
    endfunction

    logic [DATA_W-1:0] mem [DEPTH];
    logic [NBUF-1:0]   flags_d, flags_q;

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[flat_addr(wr_slot, wr_pix)] <= wr_data;
        end
    end

    always_ff @(posedge rd_clk) begin
        rd_data <= mem[flat_addr(rd_slot, rd_pix)];
    end

    // One field-start tag per slot, written with the line's first pixel.
    always_comb begin
        flags_d = flags_q;
        if (flag_we) begin
            flags_d[wr_slot] = flag_val;
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign sof_flags = flags_q;

endmodule

// File: rtl/vlr_wr_ctrl.sv
module vlr_wr_ctrl #(
    parameter int  LINE_LEN = 320,
    parameter int  NBUF     = 4,
    localparam int PIX_W    = $clog2(LINE_LEN),
    localparam int SLOT_W   = $clog2(NBUF),
    localparam int PTR_W    = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              sof,
    output logic              ram_we,
    output logic [SLOT_W-1:0] ram_slot,
    output logic [PIX_W-1:0]  ram_pix,
    output logic              flag_we,
    output logic              flag_val,
    output logic [PTR_W-1:0]  ptr_gray
);

    localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(LINE_LEN - 1);

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
    } wr_state_t;

    wr_state_t        st_d, st_q;
    logic [PIX_W-1:0] pix_now;

    always_comb begin
        st_d    = st_q;
        // A field marker always lands at position 0 of the open slot,
        // discarding whatever part of a line was there.
        pix_now = sof ? '0 : st_q.pix;
        if (valid) begin
            if (pix_now == LAST_PIX) begin
                st_d.pix = '0;
                st_d.bin = st_q.bin + 1'b1;
            end else begin
                st_d.pix = pix_now + 1'b1;
            end
        end
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_we   = valid;
    assign ram_slot = st_q.bin[SLOT_W-1:0];
    assign ram_pix  = pix_now;
    assign flag_we  = valid && (pix_now == '0);
    assign flag_val = sof;
    assign ptr_gray = st_q.gray;

endmodule

// File: rtl/vlr_gray_sync.sv
module vlr_gray_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        stage_d[0] = gray_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign bin_out = gray_to_bin(stage_q[STAGES-1]);

endmodule

// File: rtl/vlr_rd_ctrl.sv
module vlr_rd_ctrl
    import vlr_pkg::*;
#(
    parameter int  NBUF   = 4,
    localparam int SLOT_W = $clog2(NBUF),
    localparam int PTR_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [PTR_W-1:0]  wr_ptr_bin,
    input  logic [NBUF-1:0]   sof_flags,
    output logic [SLOT_W-1:0] slot,
    output logic              repeat_line,
    output logic              overtake,
    output logic              sof_line
);

    typedef struct packed {
        logic [PTR_W-1:0]   ptr;
        logic [SLOT_W-1:0]  slot;
        logic [PHASE_W-1:0] phase;
        logic               rep;
        logic               ovt;
        logic               sof;
    } rd_state_t;

    rd_state_t st_d, st_q;
    req_kind_e kind;
    logic      cand_ready;
    logic      cand_sof;

    always_comb begin
        st_d       = st_q;
        cand_ready = (wr_ptr_bin != st_q.ptr);
        cand_sof   = sof_flags[st_q.ptr[SLOT_W-1:0]];
        kind       = REQ_NONE;
        if (line_start) begin
            if (st_q.phase == PHASE_W'(NEW_RUN)) begin
                kind = REQ_REPEAT;
            end else if (cand_ready) begin
                kind = REQ_FRESH;
            end else begin
                kind = REQ_STALL;
            end
        end
        case (kind)
            REQ_FRESH: begin
                st_d.ptr   = st_q.ptr + 1'b1;
                st_d.slot  = st_q.ptr[SLOT_W-1:0];
                st_d.phase = cand_sof ? PHASE_W'(1) : st_q.phase + 1'b1;
                st_d.rep   = 1'b0;
                st_d.ovt   = 1'b0;
                st_d.sof   = cand_sof;
            end
            REQ_REPEAT: begin
                st_d.phase = '0;
                st_d.rep   = 1'b1;
                st_d.sof   = 1'b0;
            end
            REQ_STALL: begin
                st_d.rep = 1'b1;
                st_d.ovt = 1'b1;
                st_d.sof = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.slot <= SLOT_W'(NBUF - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign slot        = st_q.slot;
    assign repeat_line = st_q.rep;
    assign overtake    = st_q.ovt;
    assign sof_line    = st_q.sof;

endmodule

// File: rtl/vline_repeater.sv
module vline_repeater #(
    parameter int  DATA_W   = 16,
    parameter int  LINE_LEN = 320,
    parameter int  NBUF     = 4,
    localparam int PIX_W    = $clog2(LINE_LEN),
    localparam int SLOT_W   = $clog2(NBUF),
    localparam int PTR_W    = SLOT_W + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic              wr_sof,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_line_start,
    input  logic [PIX_W-1:0]  rd_pix_addr,
    output logic [DATA_W-1:0] rd_pix_data,
    output logic [SLOT_W-1:0] rd_slot,
    output logic              rd_repeat,
    output logic              rd_sof_line,
    output logic              rd_overtake
);

    logic              ram_we;
    logic [SLOT_W-1:0] ram_slot;
    logic [PIX_W-1:0]  ram_pix;
    logic              flag_we;
    logic              flag_val;
    logic [PTR_W-1:0]  wr_ptr_gray;
    logic [PTR_W-1:0]  wr_ptr_bin_rd;
    logic [NBUF-1:0]   sof_flags;

    vlr_wr_ctrl #(.LINE_LEN(LINE_LEN), .NBUF(NBUF)) u_wr_ctrl (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .valid    (wr_valid),
        .sof      (wr_sof),
        .ram_we   (ram_we),
        .ram_slot (ram_slot),
        .ram_pix  (ram_pix),
        .flag_we  (flag_we),
        .flag_val (flag_val),
        .ptr_gray (wr_ptr_gray)
    );

    vlr_line_ram #(.DATA_W(DATA_W), .LINE_LEN(LINE_LEN), .NBUF(NBUF)) u_ram (
        .wr_clk    (wr_clk),
        .wr_rst_n  (wr_rst_n),
        .wr_en     (ram_we),
        .wr_slot   (ram_slot),
        .wr_pix    (ram_pix),
        .wr_data   (wr_data),
        .flag_we   (flag_we),
        .flag_val  (flag_val),
        .rd_clk    (rd_clk),
        .rd_slot   (rd_slot),
        .rd_pix    (rd_pix_addr),
        .rd_data   (rd_pix_data),
        .sof_flags (sof_flags)
    );

    vlr_gray_sync #(.W(PTR_W), .STAGES(2)) u_ptr_sync (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (wr_ptr_gray),
        .bin_out (wr_ptr_bin_rd)
    );

    vlr_rd_ctrl #(.NBUF(NBUF)) u_rd_ctrl (
        .clk         (rd_clk),
        .rst_n       (rd_rst_n),
        .line_start  (rd_line_start),
        .wr_ptr_bin  (wr_ptr_bin_rd),
        .sof_flags   (sof_flags),
        .slot        (rd_slot),
        .repeat_line (rd_repeat),
        .overtake    (rd_overtake),
        .sof_line    (rd_sof_line)
    );

endmodule

// File: rtl/vline_repeater_chk.sv
module vline_repeater_chk
    import vlr_pkg::*;
#(
    parameter int  NBUF   = 4,
    localparam int SLOT_W = $clog2(NBUF),
    localparam int PTR_W  = SLOT_W + 1
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_line_start,
    input logic [SLOT_W-1:0] rd_slot,
    input logic              rd_repeat,
    input logic              rd_overtake,
    input logic              rd_sof_line,
    input logic [PTR_W-1:0]  wr_ptr_gray
);

    logic               lstart_d, lstart_q;
    logic [PHASE_W-1:0] run_d, run_q;

    // Independent count of fresh lines since the last re-read or field start.
    always_comb begin
        lstart_d = rd_line_start;
        run_d    = run_q;
        if (lstart_q) begin
            if (rd_repeat) begin
                run_d = '0;
            end else if (rd_sof_line) begin
                run_d = PHASE_W'(1);
            end else begin
                run_d = run_q + 1'b1;
            end
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            lstart_q <= 1'b0;
            run_q    <= '0;
        end else begin
            lstart_q <= lstart_d;
            run_q    <= run_d;
        end
    end

    AST_GRAY_ONE_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wr_ptr_gray ^ $past(wr_ptr_gray)) <= 1); // R2

    AST_FLAG_MEANS_REREAD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_overtake |-> rd_repeat); // R2

    AST_REPEAT_HOLDS_SLOT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_line_start ##1 rd_repeat |-> $stable(rd_slot)); // R3

    AST_RUN_LIMIT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        run_q <= PHASE_W'(NEW_RUN)); // R3

    AST_REPEAT_AFTER_RUN: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        lstart_q && (run_q == PHASE_W'(NEW_RUN)) |-> rd_repeat); // R3

    AST_FRESH_ADVANCES: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_line_start ##1 !rd_repeat |-> rd_slot == ($past(rd_slot) + 1'b1)); // R4

    AST_SOF_ONLY_FRESH: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_sof_line |-> !rd_repeat); // R6

    AST_FRESH_CLEARS_FLAG: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_line_start ##1 !rd_repeat |-> !rd_overtake); // R7

endmodule

bind vline_repeater vline_repeater_chk #(.NBUF(NBUF)) u_chk (
    .wr_clk        (wr_clk),
    .wr_rst_n      (wr_rst_n),
    .rd_clk        (rd_clk),
    .rd_rst_n      (rd_rst_n),
    .rd_line_start (rd_line_start),
    .rd_slot       (rd_slot),
    .rd_repeat     (rd_repeat),
    .rd_overtake   (rd_overtake),
    .rd_sof_line   (rd_sof_line),
    .wr_ptr_gray   (wr_ptr_gray)
);

// File: tb/vline_repeater_bench.sv
module vline_repeater_bench;

    localparam int DW = 16;
    localparam int LL = 16;
    localparam int NB = 4;
    localparam int PW = $clog2(LL);
    localparam int SW = $clog2(NB);

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n, rd_rst_n;
    logic          wr_valid, wr_sof;
    logic [DW-1:0] wr_data;
    logic          rd_line_start;
    logic [PW-1:0] rd_pix_addr;
    logic [DW-1:0] rd_pix_data;
    logic [SW-1:0] rd_slot;
    logic          rd_repeat, rd_sof_line, rd_overtake;

    always #2  rd_clk = ~rd_clk;
    always #12 wr_clk = ~wr_clk;

    vline_repeater #(.DATA_W(DW), .LINE_LEN(LL), .NBUF(NB)) u_vline_repeater (
        .wr_clk        (wr_clk),
        .wr_rst_n      (wr_rst_n),
        .wr_valid      (wr_valid),
        .wr_sof        (wr_sof),
        .wr_data       (wr_data),
        .rd_clk        (rd_clk),
        .rd_rst_n      (rd_rst_n),
        .rd_line_start (rd_line_start),
        .rd_pix_addr   (rd_pix_addr),
        .rd_pix_data   (rd_pix_data),
        .rd_slot       (rd_slot),
        .rd_repeat     (rd_repeat),
        .rd_sof_line   (rd_sof_line),
        .rd_overtake   (rd_overtake)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Expected-behaviour model, built from the requirements.
    int phase_m    = 0;
    int wr_cnt     = 0;
    int rd_cnt     = 0;
    int cur_slot_m = NB - 1;
    int cur_id_m   = 0;
    int ovt_m      = 0;
    bit loaded_m   = 1'b0;
    int ids  [NB];
    bit sofs [NB];
    int next_id  = 1;
    int dut_reps = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int pix_val(input int id, input int p);
        return (id % 256) * 256 + p;
    endfunction

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic write_pix(input int id, input int from, input int to, input bit sof_first);
        for (int p = from; p <= to; p++) begin
            @(negedge wr_clk);
            wr_valid = 1'b1;
            wr_sof   = sof_first && (p == from);
            wr_data  = DW'(pix_val(id, p));
        end
        @(negedge wr_clk);
        wr_valid = 1'b0;
        wr_sof   = 1'b0;
    endtask

    task automatic feed_line(input bit sof);
        int id;
        int s;
        id = next_id % 256;
        next_id++;
        write_pix(id, 0, LL - 1, sof);
        s = wr_cnt % NB;
        ids[s]  = id;
        sofs[s] = sof;
        wr_cnt++;
        settle();
    endtask

    task automatic read_pix(input int p, output int val);
        @(negedge rd_clk);
        rd_pix_addr = PW'(p);
        @(negedge rd_clk);
        val = int'(rd_pix_data);
    endtask

    task automatic req_line(input string tag);
        int er, es, eo, ef, s, v;
        @(negedge rd_clk);
        rd_line_start = 1'b1;
        @(negedge rd_clk);
        rd_line_start = 1'b0;
        if (phase_m == 5) begin
            er = 1; es = cur_slot_m; eo = ovt_m; ef = 0;
            phase_m = 0;
        end else if (wr_cnt > rd_cnt) begin
            s = rd_cnt % NB;
            er = 0; es = s; eo = 0; ef = int'(sofs[s]);
            phase_m    = sofs[s] ? 1 : phase_m + 1;
            cur_slot_m = s;
            cur_id_m   = ids[s];
            rd_cnt++;
            loaded_m = 1'b1;
            ovt_m    = 0;
        end else begin
            er = 1; es = cur_slot_m; eo = 1; ef = 0;
            ovt_m = 1;
        end
        chk(tag, "rd_repeat", int'(rd_repeat), er);
        chk(tag, "rd_slot", int'(rd_slot), es);
        chk(tag, "rd_overtake", int'(rd_overtake), eo);
        chk(tag, "rd_sof_line", int'(rd_sof_line), ef);
        if (rd_repeat) dut_reps++;
        if (loaded_m) begin
            read_pix(0, v);
            chk("R5", "pixel 0", v, pix_val(cur_id_m, 0));
            read_pix(LL - 1, v);
            chk("R5", "last pixel", v, pix_val(cur_id_m, LL - 1));
        end
    endtask

    task automatic step(input string tag);
        if (phase_m != 5 && wr_cnt == rd_cnt) feed_line(1'b0);
        req_line(tag);
    endtask

    task automatic t_reset();
        chk("R1", "rd_slot", int'(rd_slot), NB - 1);
        chk("R1", "rd_repeat", int'(rd_repeat), 0);
        chk("R1", "rd_overtake", int'(rd_overtake), 0);
        chk("R1", "rd_sof_line", int'(rd_sof_line), 0);
    endtask

    task automatic t_stall();
        int id;
        req_line("R2");                       // nothing written yet
        id = next_id % 256;
        next_id++;
        write_pix(id, 0, 4, 1'b0);            // partial line
        settle();
        req_line("R2");                       // still not committed
        chk("R2", "overtake on partial line", int'(rd_overtake), 1);
        write_pix(id, 5, LL - 1, 1'b0);       // finish the same line
        ids[wr_cnt % NB]  = id;
        sofs[wr_cnt % NB] = 1'b0;
        wr_cnt++;
        settle();
        req_line("R7");                       // fresh line clears the flag
        chk("R4", "first fresh slot", int'(rd_slot), 0);
    endtask

    task automatic t_pattern();
        for (int i = 0; i < 9; i++) step("R3");
    endtask

    task automatic t_sof_restart();
        int sof_id, v;
        write_pix(next_id % 256, 0, 5, 1'b0); // abandoned by the field marker
        next_id++;
        settle();
        req_line("R8");                       // partial line must not be taken
        sof_id = next_id % 256;
        feed_line(1'b1);
        for (int i = 0; i < 8; i++) begin
            step("R6");
            if (rd_sof_line) begin
                read_pix(2, v);
                chk("R8", "restarted line pixel 2", v, pix_val(sof_id, 2));
            end
        end
    endtask

    task automatic t_frame();
        int reps0, rd0, in_lines;
        if (phase_m == 5) req_line("R9");
        reps0    = dut_reps;
        rd0      = rd_cnt;
        in_lines = 0;
        for (int r = 0; r < 288; r++) begin
            if (phase_m != 5) begin
                feed_line(in_lines == 0);
                in_lines++;
            end
            req_line("R9");
        end
        chk("R9", "repeats per field", dut_reps - reps0, 48);
        chk("R9", "fresh lines per field", rd_cnt - rd0, 240);
        chk("R9", "input lines used", in_lines, 240);
    endtask

    initial begin
        repeat (150000) @(posedge rd_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wr_rst_n      = 1'b0;
        rd_rst_n      = 1'b0;
        wr_valid      = 1'b0;
        wr_sof        = 1'b0;
        wr_data       = '0;
        rd_line_start = 1'b0;
        rd_pix_addr   = '0;
        repeat (3) @(negedge wr_clk);
        wr_rst_n = 1'b1;
        @(negedge rd_clk);
        rd_rst_n = 1'b1;
        @(negedge rd_clk);
        t_reset();
        t_stall();
        t_pattern();
        t_sof_restart();
        t_frame();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule